// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block is a data cache with a parameterized number of ways and sets and 64-byte lines. It sits between a processor core and the next memory level. The core side issues one 32-bit word access at a time, a read or a byte-masked write. The memory side moves whole 512-bit lines. Writes stay in the cache and set the line's dirty flag. Memory is updated only when a dirty line is chosen for eviction, and that line is written out before the new line is fetched. A write miss allocates: the line is fetched first and the write is then merged into it.

The byte address splits into three parts. The low six bits are the offset within a line. The set index sits directly above the offset, and the tag takes the remaining upper bits. As a result, neighbouring lines land in different sets. All ways of the addressed set are compared at once. While a miss is being serviced the core is held off, and only one miss is outstanding at a time. A two-bit run-time input selects the victim policy: least recently used, per-set round-robin, pseudo-random from a free-running 16-bit LFSR, or "not the most recently used". Whatever the policy, an empty way is always filled before any valid line is replaced.

Top module: `cache_top`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1 and both `rsp_valid` and `mem_valid` are 0. Every line is invalid, so the first access to any address misses.
- R2: Address bits [5:0] are the byte offset within a line and bits [5:2] select the word. The next log2(SETS) bits are the set index and the remaining upper bits are the tag. Line requests to memory are 64-byte aligned (`mem_addr[5:0]` = 0).
- R3: A read that hits returns the word with `rsp_valid` high in the cycle after acceptance, and causes no memory transaction.
- R4: A write hit merges `req_wdata` into the line for each set bit of `req_be` (bit i covers byte i, bits 8i+7:8i). It marks the line dirty, acknowledges with `rsp_valid` one cycle after acceptance, and causes no memory transaction.
- R5: On a miss, `req_ready` stays 0 from the cycle after acceptance until the cycle in which `rsp_valid` is asserted. `mem_valid` is never high while `req_ready` is high. A response is preceded either by an accepted request one cycle earlier or by a completed fill two cycles earlier.
- R6: A write miss fetches the line from memory, then merges the write under byte enables. Unmasked bytes keep the memory contents.
- R7: When the victim is valid and dirty, the whole line is written to its own line address (`mem_we`=1). The fill read follows immediately. A clean victim produces no write.
- R8: If the addressed set has an invalid way, the lowest-numbered invalid way is filled, whatever the policy.
- R9: With `repl_sel` = 0 (LRU), the victim is the least recently accessed way of the set. Both hits and completed misses count as accesses.
- R10: With `repl_sel` = 1 (round-robin), each set keeps a pointer that is set to (filled way + 1) mod WAYS on every fill, and the victim is the way it points to.
- R11: With `repl_sel` = 2 (pseudo-random), the victim is the low log2(WAYS) bits of a free-running 16-bit LFSR (taps 16, 14, 13, 11).
- R12: With `repl_sel` = 3 (not-MRU), the victim is (most recently accessed way + 1) mod WAYS within the set.
- R13: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_we` and `mem_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| repl_sel | input | 2 | Victim policy: 0 LRU, 1 round-robin, 2 pseudo-random, 3 not-MRU |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Cache can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write word |
| req_be | input | 4 | Byte enables for writes |
| rsp_valid | output | 1 | Access complete (read data valid for reads) |
| rsp_rdata | output | 32 | Read word |
| mem_valid | output | 1 | Line transaction to memory pending |
| mem_we | output | 1 | 1 = write-back, 0 = fill read |
| mem_addr | output | ADDR_W | Line-aligned byte address |
| mem_wdata | output | 512 | Line being written back |
| mem_ready | input | 1 | Memory completes the transaction; fill data valid |
| mem_rdata | input | 512 | Fill line |

## Verification
Corrupt tag, valid or dirty state shows at the ports within a few accesses. A wrong tag or valid bit turns an expected one-cycle hit into a stalled miss, or returns a stale word. A lost dirty bit is exposed once the line is forced out and read back, because the value that returns from memory is the pre-write one. A wrong victim choice is seen as a miss on a line that should still be present, or as a write-back count or address that differs from the one the policy implies. The bench checks the latency of every access and compares the data against a word-level model of memory.

// File: rtl/cache_pkg.sv
// Shared constants, encodings and helpers for the write-back cache.
// Assumes 64-byte lines and 32-bit core words.
package cache_pkg;
    localparam int OFF_W  = 6;
    localparam int WORD_W = 32;
    localparam int LINE_W = (1 << OFF_W) * 8;
    localparam int WSEL_W = OFF_W - 2;

    typedef enum logic [1:0] {
        POL_LRU  = 2'd0,
        POL_FIFO = 2'd1,
        POL_RAND = 2'd2,
        POL_NMRU = 2'd3
    } repl_pol_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WBACK,
        ST_FILL,
        ST_FINISH
    } fsm_e;

    // Byte-masked merge of one word into a line.
    function automatic logic [LINE_W-1:0] merge_word(
        input logic [LINE_W-1:0] line,
        input logic [WSEL_W-1:0] wsel,
        input logic [3:0]        be,
        input logic [WORD_W-1:0] wdata
    );
        logic [LINE_W-1:0] res;
        res = line;
        for (int b = 0; b < 4; b++) begin
            if (be[b]) res[int'(wsel) * WORD_W + b * 8 +: 8] = wdata[b * 8 +: 8];
        end
        return res;
    endfunction
endpackage

// File: rtl/cache_tag_match.sv
// Parallel tag compare across all ways of one set.
// Assumes at most one valid way holds a given tag.
module cache_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]       row_valid,
    input  logic [WAYS*TAG_W-1:0] row_tags,
    input  logic [TAG_W-1:0]      look_tag,
    output logic [WAYS-1:0]       hit_vec,
    output logic                  any_hit,
    output logic [WAY_W-1:0]      hit_way
);
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_vec[g] = row_valid[g] && (row_tags[g*TAG_W +: TAG_W] == look_tag);
    end

    // Encode the matching way number.
    always_comb begin
        any_hit = |hit_vec;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/cache_repl.sv
// Victim selection with four run-time policies and invalid-first fill.
// Assumes WAYS and SETS are powers of two; WAYS=1 always picks way 0.
module cache_repl
    import cache_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int SETS = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       policy,
    input  logic [IDX_W-1:0] look_set,
    input  logic [WAYS-1:0]  look_valid,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    output logic [WAY_W-1:0] victim
);
    if (WAYS == 1) begin : g_direct
        assign victim = '0;
    end else begin : g_assoc
        logic [WAY_W-1:0] age_q  [SETS][WAYS];
        logic [WAY_W-1:0] fifo_q [SETS];
        logic [WAY_W-1:0] mru_q  [SETS];
        logic [15:0]      lfsr_q;
        logic [WAY_W-1:0] lru_way, pol_way, free_way;
        logic             any_free;

        // Free-running pseudo-random source.
        always_ff @(posedge clk) begin
            if (!rst_n) lfsr_q <= 16'hACE1;
            else        lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
        end

        // Recency ages: 0 is newest, WAYS-1 is oldest.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++)
                    for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
            end else if (touch_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == touch_way)
                        age_q[touch_set][w] <= '0;
                    else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                        age_q[touch_set][w] <= age_q[touch_set][w] + WAY_W'(1);
                end
            end
        end

        // Round-robin pointer and most-recent way per set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) begin
                    fifo_q[s] <= '0;
                    mru_q[s]  <= '0;
                end
            end else begin
                if (fill_en)  fifo_q[fill_set] <= fill_way + WAY_W'(1);
                if (touch_en) mru_q[touch_set] <= touch_way;
            end
        end

        // Pick the victim: lowest invalid way first, else the policy's choice.
        always_comb begin
            lru_way = '0;
            for (int w = 0; w < WAYS; w++)
                if (age_q[look_set][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
            case (policy)
                POL_LRU:  pol_way = lru_way;
                POL_FIFO: pol_way = fifo_q[look_set];
                POL_RAND: pol_way = lfsr_q[WAY_W-1:0];
                default:  pol_way = mru_q[look_set] + WAY_W'(1);
            endcase
            any_free = 1'b0;
            free_way = '0;
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (!look_valid[w]) begin
                    any_free = 1'b1;
                    free_way = WAY_W'(w);
                end
            end
            victim = any_free ? free_way : pol_way;
        end
    end
endmodule

// File: rtl/cache_top.sv
// Set-associative write-back, write-allocate data cache, one miss at a time.
// Assumes power-of-two SETS and WAYS, SETS >= 2, and ADDR_W > offset + index width.
module cache_top
    import cache_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SETS   = 4,
    parameter int WAYS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        repl_sel,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [3:0]        req_be,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [511:0]      mem_wdata,
    input  logic              mem_ready,
    input  logic [511:0]      mem_rdata
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [LINE_W-1:0] data_q  [SETS][WAYS];
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [WAYS-1:0]   valid_q [SETS];
    logic [WAYS-1:0]   dirty_q [SETS];

    fsm_e              state_q;
    logic              q_we;
    logic [ADDR_W-1:0] q_addr;
    logic [31:0]       q_wdata;
    logic [3:0]        q_be;
    logic [WAY_W-1:0]  q_way;

    logic [IDX_W-1:0]  r_idx, q_idx, acc_set;
    logic [TAG_W-1:0]  r_tag, q_tag;
    logic [WAYS*TAG_W-1:0] row_tags;
    logic [WAYS-1:0]   hit_vec;
    logic              any_hit;
    logic [WAY_W-1:0]  hit_way, victim, acc_way;
    logic              acc_en, acc_finish, acc_we, fill_done;
    logic [WSEL_W-1:0] acc_wsel;
    logic [3:0]        acc_be;
    logic [31:0]       acc_wdata, acc_word;
    logic [LINE_W-1:0] acc_line;
    logic              unused_lsb;

    assign r_idx      = req_addr[OFF_W +: IDX_W];
    assign r_tag      = req_addr[ADDR_W-1 -: TAG_W];
    assign q_idx      = q_addr[OFF_W +: IDX_W];
    assign q_tag      = q_addr[ADDR_W-1 -: TAG_W];
    assign unused_lsb = ^{req_addr[1:0], q_addr[1:0]};
    assign req_ready  = (state_q == ST_IDLE);
    assign fill_done  = (state_q == ST_FILL) && mem_ready;

    // Gather the addressed set's tags for the comparators.
    always_comb begin
        for (int w = 0; w < WAYS; w++) row_tags[w*TAG_W +: TAG_W] = tag_q[r_idx][w];
    end

    cache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .row_valid(valid_q[r_idx]), .row_tags(row_tags), .look_tag(r_tag),
        .hit_vec(hit_vec), .any_hit(any_hit), .hit_way(hit_way)
    );

    cache_repl #(.WAYS(WAYS), .SETS(SETS)) u_repl (
        .clk(clk), .rst_n(rst_n), .policy(repl_sel),
        .look_set(r_idx), .look_valid(valid_q[r_idx]),
        .touch_en(acc_en), .touch_set(acc_set), .touch_way(acc_way),
        .fill_en(fill_done), .fill_set(q_idx), .fill_way(q_way),
        .victim(victim)
    );

    // Select the access being performed: an idle-state hit or a finished miss.
    always_comb begin
        acc_finish = (state_q == ST_FINISH);
        acc_en     = acc_finish || ((state_q == ST_IDLE) && req_valid && any_hit);
        acc_set    = acc_finish ? q_idx   : r_idx;
        acc_way    = acc_finish ? q_way   : hit_way;
        acc_we     = acc_finish ? q_we    : req_we;
        acc_wsel   = acc_finish ? q_addr[OFF_W-1:2] : req_addr[OFF_W-1:2];
        acc_be     = acc_finish ? q_be    : req_be;
        acc_wdata  = acc_finish ? q_wdata : req_wdata;
        acc_line   = data_q[acc_set][acc_way];
        acc_word   = acc_line[int'(acc_wsel) * WORD_W +: WORD_W];
    end

    // Drive the line port from the pending miss.
    always_comb begin
        mem_valid = (state_q == ST_WBACK) || (state_q == ST_FILL);
        mem_we    = (state_q == ST_WBACK);
        mem_addr  = mem_we ? {tag_q[q_idx][q_way], q_idx, OFF_W'(0)} : {q_tag, q_idx, OFF_W'(0)};
        mem_wdata = data_q[q_idx][q_way];
    end

    // Line storage: fills and merged writes.
    always_ff @(posedge clk) begin
        if (fill_done) begin
            data_q[q_idx][q_way] <= mem_rdata;
            tag_q[q_idx][q_way]  <= q_tag;
        end else if (acc_en && acc_we) begin
            data_q[acc_set][acc_way] <= merge_word(acc_line, acc_wsel, acc_be, acc_wdata);
        end
    end

    // Miss sequencing, line state flags and core response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            q_we      <= 1'b0;
            q_addr    <= '0;
            q_wdata   <= '0;
            q_be      <= '0;
            q_way     <= '0;
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else begin
            rsp_valid <= acc_en;
            if (acc_en) rsp_rdata <= acc_word;
            if (acc_en && acc_we) dirty_q[acc_set][acc_way] <= 1'b1;
            case (state_q)
                ST_IDLE: if (req_valid && !any_hit) begin
                    q_we    <= req_we;
                    q_addr  <= req_addr;
                    q_wdata <= req_wdata;
                    q_be    <= req_be;
                    q_way   <= victim;
                    state_q <= (valid_q[r_idx][victim] && dirty_q[r_idx][victim]) ? ST_WBACK : ST_FILL;
                end
                ST_WBACK: if (mem_ready) begin
                    dirty_q[q_idx][q_way] <= 1'b0;
                    state_q <= ST_FILL;
                end
                ST_FILL: if (mem_ready) begin
                    valid_q[q_idx][q_way] <= 1'b1;
                    dirty_q[q_idx][q_way] <= 1'b0;
                    state_q <= ST_FINISH;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cache_top_chk.sv
// Port-level protocol properties of the cache, bound into cache_top.
// Assumes synchronous active-low reset.
module cache_top_chk #(
    parameter int WAYS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            mem_valid,
    input logic            mem_we,
    input logic            mem_ready,
    input logic [5:0]      mem_off,
    input logic [WAYS-1:0] hit_vec
);
    a_r13_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_we) && $stable(mem_off));
    a_r5_no_accept_during_mem: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready);
    a_r7_fill_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we && mem_ready |=> mem_valid && !mem_we);
    a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    a_r2_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_off == 6'd0);
    a_r5_rsp_source: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready) || $past(mem_valid && !mem_we && mem_ready, 2));
endmodule

bind cache_top cache_top_chk #(.WAYS(WAYS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_ready(mem_ready), .mem_off(mem_addr[5:0]), .hit_vec(hit_vec)
);

// File: tb/tb_cache_top.sv
module tb_cache_top;
    localparam int ADDR_W = 16;
    localparam int NV = 21;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic [1:0] repl_sel = 2'd0;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0] req_be = '0;
    logic req_ready, rsp_valid, mem_valid, mem_we;
    logic [31:0] rsp_rdata;
    logic [ADDR_W-1:0] mem_addr;
    logic [511:0] mem_wdata;
    logic mem_ready;
    logic [511:0] mem_rdata;

    cache_top #(.ADDR_W(ADDR_W), .SETS(4), .WAYS(4)) dut (
        .clk(clk), .rst_n(rst_n), .repl_sel(repl_sel),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    int errors = 0, checks = 0;
    int wb_cnt = 0, fill_cnt = 0;
    logic [ADDR_W-1:0] last_wb = '0;
    bit stall_bad = 1'b0;
    logic [31:0] model [int];
    logic [31:0] bmem [int];

    // {we, addr, wdata, expect_hit, expect_writeback}; policy LRU, 4 sets x 4 ways
    localparam logic [50:0] VEC [NV] = '{
        {1'b0, 16'h0000, 32'h0,        1'b0, 1'b0},
        {1'b0, 16'h0004, 32'h0,        1'b1, 1'b0},
        {1'b1, 16'h0008, 32'h11112222, 1'b1, 1'b0},
        {1'b0, 16'h0008, 32'h0,        1'b1, 1'b0},
        {1'b1, 16'h0140, 32'h33334444, 1'b0, 1'b0},
        {1'b0, 16'h0140, 32'h0,        1'b1, 1'b0},
        {1'b0, 16'h0100, 32'h0,        1'b0, 1'b0},
        {1'b0, 16'h0200, 32'h0,        1'b0, 1'b0},
        {1'b0, 16'h0300, 32'h0,        1'b0, 1'b0},
        {1'b0, 16'h0000, 32'h0,        1'b1, 1'b0},
        {1'b0, 16'h0400, 32'h0,        1'b0, 1'b0},
        {1'b0, 16'h0100, 32'h0,        1'b0, 1'b0},
        {1'b0, 16'h0000, 32'h0,        1'b1, 1'b0},
        {1'b0, 16'h0300, 32'h0,        1'b1, 1'b0},
        {1'b0, 16'h0400, 32'h0,        1'b1, 1'b0},
        {1'b0, 16'h0100, 32'h0,        1'b1, 1'b0},
        {1'b0, 16'h0500, 32'h0,        1'b0, 1'b1},
        {1'b0, 16'h0008, 32'h0,        1'b0, 1'b0},
        {1'b0, 16'h0140, 32'h0,        1'b1, 1'b0},
        {1'b1, 16'h0044, 32'h55556666, 1'b0, 1'b0},
        {1'b0, 16'h0044, 32'h0,        1'b1, 1'b0}
    };

    function automatic logic [31:0] pat(input int wa);
        return {wa[15:0], ~wa[15:0]};
    endfunction
    function automatic logic [31:0] model_rd(input int wa);
        return model.exists(wa) ? model[wa] : pat(wa);
    endfunction
    function automatic logic [31:0] bmem_rd(input int wa);
        return bmem.exists(wa) ? bmem[wa] : pat(wa);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Next-level memory: answers each line transaction after three cycles.
    initial begin : mem_model
        int dly;
        logic [ADDR_W-1:0] seen;
        mem_ready = 1'b0;
        mem_rdata = '0;
        dly = 0;
        seen = '0;
        forever begin
            @(negedge clk);
            if (mem_ready) mem_ready = 1'b0;
            else if (mem_valid) begin
                if (dly == 0) seen = mem_addr;
                if (dly == 2) begin
                    chk(mem_addr == seen, "R13 line address held", 32'(mem_addr), 32'(seen));
                    if (mem_we) begin
                        for (int w = 0; w < 16; w++) bmem[(int'(mem_addr) >> 2) + w] = mem_wdata[w*32 +: 32];
                        wb_cnt++;
                        last_wb = mem_addr;
                    end else begin
                        for (int w = 0; w < 16; w++) mem_rdata[w*32 +: 32] = bmem_rd((int'(mem_addr) >> 2) + w);
                        fill_cnt++;
                    end
                    mem_ready = 1'b1;
                    dly = 0;
                end else dly++;
            end
        end
    end

    task automatic do_reset(input logic [1:0] pol);
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        repl_sel = pol;
        model.delete();
        bmem.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic access(input bit we, input logic [15:0] a, input logic [31:0] d,
                          input logic [3:0] be, output logic [31:0] rd, output int lat);
        int wa;
        logic [31:0] cur;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid) begin
            if (req_ready) stall_bad = 1'b1;
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
        if (we) begin
            wa = int'(a) >> 2;
            cur = model_rd(wa);
            for (int b = 0; b < 4; b++) if (be[b]) cur[b*8 +: 8] = d[b*8 +: 8];
            model[wa] = cur;
        end
    endtask

    task automatic expect_hit(input logic [15:0] a, input bit hit, input string tag);
        logic [31:0] rd;
        int lat;
        access(1'b0, a, 32'h0, 4'hF, rd, lat);
        chk((lat == 1) == hit, tag, 32'(lat), hit ? 32'd1 : 32'd2);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R5 watchdog: actual=hung expected=complete");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] rd, exp;
        int lat, wb0, txn0;
        do_reset(2'd0);
        #1;
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready after reset", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk(mem_valid == 1'b0, "R1 mem_valid after reset", 32'(mem_valid), 32'd0);

        // Table walk: R2 R3 R4 R6 R7 R9 under LRU
        for (int i = 0; i < NV; i++) begin
            logic [50:0] e;
            e = VEC[i];
            wb0 = wb_cnt;
            exp = model_rd(int'(e[49:34]) >> 2);
            access(e[50], e[49:34], e[33:2], 4'hF, rd, lat);
            if (!e[50]) chk(rd == exp, "R3/R2 read data", rd, exp);
            chk((lat == 1) == e[1], "R9/R1 hit or miss", 32'(lat), e[1] ? 32'd1 : 32'd2);
            chk((wb_cnt - wb0) == int'(e[0]), "R7 write-back count", 32'(wb_cnt - wb0), 32'(e[0]));
        end
        chk(last_wb == 16'h0000, "R7 write-back address", 32'(last_wb), 32'h0);

        // R6: partial write miss merges over fetched line
        access(1'b1, 16'h2010, 32'hDEADBEEF, 4'b0011, rd, lat);
        chk(lat > 1, "R6 write miss stalls for fill", 32'(lat), 32'd2);
        access(1'b0, 16'h2010, 32'h0, 4'hF, rd, lat);
        exp = {pat(16'h2010 >> 2) >> 16, 16'hBEEF};
        chk(rd == exp, "R6 merged word", rd, exp);

        // R4: write hit, upper bytes only, no memory traffic
        txn0 = wb_cnt + fill_cnt;
        access(1'b1, 16'h2014, 32'hA1B2C3D4, 4'b1100, rd, lat);
        chk(lat == 1 && (wb_cnt + fill_cnt) == txn0, "R4 write hit without memory traffic", 32'(lat), 32'd1);
        access(1'b0, 16'h2014, 32'h0, 4'hF, rd, lat);
        exp = {16'hA1B2, pat(16'h2014 >> 2) & 32'h0000FFFF} | 32'h0;
        exp = {16'hA1B2, exp[15:0]};
        chk(rd == exp, "R4 byte-enable merge", rd, exp);
        chk(stall_bad == 1'b0, "R5 no ready during miss", 32'(stall_bad), 32'd0);

        // R10: round-robin
        do_reset(2'd1);
        for (int w = 0; w < 4; w++) expect_hit(16'(16'h0080 + w * 16'h0100), 1'b0, "R8 fill empty way");
        expect_hit(16'h0080, 1'b1, "R10 touch oldest");
        expect_hit(16'h0480, 1'b0, "R10 new line misses");
        expect_hit(16'h0180, 1'b1, "R10 second line kept");
        expect_hit(16'h0080, 1'b0, "R10 first-filled line evicted");

        // R12: not most recently used
        do_reset(2'd3);
        for (int w = 0; w < 4; w++) expect_hit(16'(16'h0080 + w * 16'h0100), 1'b0, "R8 fill empty way");
        expect_hit(16'h0180, 1'b1, "R12 touch way 1");
        expect_hit(16'h0480, 1'b0, "R12 new line misses");
        expect_hit(16'h0180, 1'b1, "R12 MRU kept");
        expect_hit(16'h0080, 1'b1, "R12 way 0 kept");
        expect_hit(16'h0380, 1'b1, "R12 way 3 kept");
        expect_hit(16'h0280, 1'b0, "R12 way after MRU evicted");

        // R11 and R8: random policy fills empty ways first
        do_reset(2'd2);
        for (int w = 0; w < 4; w++) access(1'b1, 16'(16'h0080 + w * 16'h0100), 32'(w + 7), 4'hF, rd, lat);
        for (int w = 0; w < 4; w++) expect_hit(16'(16'h0080 + w * 16'h0100), 1'b1, "R8 all four ways resident");
        wb0 = wb_cnt;
        expect_hit(16'h0480, 1'b0, "R11 miss in full set");
        chk(wb_cnt - wb0 == 1, "R11 one dirty victim written", 32'(wb_cnt - wb0), 32'd1);
        chk(last_wb[7:0] == 8'h80 && last_wb[15:8] < 8'h04, "R11 victim from same set", 32'(last_wb), 32'h0080);
        chk(bmem_rd(int'(last_wb) >> 2) == 32'(last_wb[15:8]) + 32'd7, "R7 written-back data",
            bmem_rd(int'(last_wb) >> 2), 32'(last_wb[15:8]) + 32'd7);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule